// File: doc/BRIEF.md
# Booth Radix-2 Sequential Signed Multiplier

This block forms the signed product of two two's-complement words of `WORD_W` bits (default 4), giving a `2*WORD_W`-bit two's-complement result. It visits the multiplier one bit at a time. For each bit it looks at that bit together with the bit to its right; below the least significant bit that neighbour is taken as 0. The pair selects one of three actions on the aligned multiplicand: add it, subtract it, or leave the sum alone. A run of ones in the multiplier therefore costs one subtraction where the run starts and one addition where it ends. It does not cost one addition per bit.

A controller and a datapath share the work. The controller has four named states:

- `ST_IDLE`: after reset. Ready is high unless reset is held.
- `ST_EXAM`: examines the current bit pair.
- `ST_SHIFT`: the shift that follows an add or subtract.
- `ST_DONE`: the result is held and Ready is high.

The transitions are:

- `ST_IDLE` or `ST_DONE` with start: load, go to `ST_EXAM`.
- `ST_IDLE` or `ST_DONE` without start: stay.
- `ST_EXAM` with an add or subtract code on a pair that is not the last: apply it, go to `ST_SHIFT`.
- `ST_EXAM` with a do-nothing code on a pair that is not the last: shift, stay in `ST_EXAM`.
- `ST_EXAM` on the last pair, whatever the code: apply the code, go to `ST_DONE` with no shift.
- `ST_SHIFT`: shift, go to `ST_EXAM`.

A user presents both operands and pulses start while ready is high. Ready drops on the following cycle. When ready rises again, the product is valid and stays valid until the next start. A start seen in `ST_DONE` begins the next operation at once.

Top module: `booth_seq_mult`

## Requirements
- R1: Reset (`rst`, active high) acts asynchronously. While `rst` is high, `ready` is 0 and `product` is 0. After release the block sits in `ST_IDLE` with `ready` = 1.
- R2: A start sampled while `ready` is 1 loads the operands. On the next cycle `ready` is 0 and `product` is 0. The multiplicand is sign-extended to `2*WORD_W` bits on load.
- R3: The bit pair code is {m[i], m[i-1]} with m[-1] = 0. Code 2'b01 adds the aligned multiplicand, code 2'b10 subtracts it, and codes 2'b00 and 2'b11 leave the sum unchanged.
- R4: After an add or subtract on any pair except the last, exactly one shift cycle (`ST_SHIFT`) runs before the next pair is examined. The last pair moves straight to `ST_DONE` without a shift.
- R5: `ready` returns exactly `WORD_W + n` clock edges after the load edge. Here n is the number of pairs, among the first `WORD_W-1` pairs, whose code is 2'b01 or 2'b10.
- R6: `ready` stays 0 while an operation runs. During that time, a start pulse and any change of the operand inputs have no effect on the result.
- R7: When `ready` rises after an operation, `product` equals the signed product of the loaded operands as a `2*WORD_W`-bit two's-complement value.
- R8: A start in `ST_DONE` reloads the operands and begins a new operation at once, with the same timing as a start from `ST_IDLE`.
- R9: While `ready` is 1 and start is low, `ready` stays 1 and `product` holds its value whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin an operation when ready is high |
| word_a | input | WORD_W | Multiplicand, two's complement |
| word_b | input | WORD_W | Multiplier, two's complement |
| ready | output | 1 | Idle or finished; product valid after an operation |
| product | output | 2*WORD_W | Signed product |

## Verification
The block loads on the edge that samples start. Ready is therefore low, and the product is zero, at the first falling edge after that load edge. The bench works out each operand pair's latency, `WORD_W` plus the number of non-zero Booth digits below the top pair, and counts rising edges from the load edge. It expects ready to rise on exactly that edge, and it compares the product at the falling edge that follows. Ignored start pulses and operand changes are placed on the second busy edge, which can never be the final edge. Their lack of effect then shows in that same product and latency comparison. Reset effects are sampled a fraction of a cycle after reset changes, so that the asynchronous path is observed apart from any clock edge.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXAM  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } booth_state_t;

    // Value of each action equals the pair code that selects it
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic [1:0] pair,
    output booth_op_t  op
);

    // pair = {current multiplier bit, previous multiplier bit}
    always_comb begin
        unique case (pair)
            2'b01:   op = OP_ADD;   // run of ones has ended
            2'b10:   op = OP_SUB;   // run of ones begins
            default: op = OP_NONE;  // inside a run of zeros or ones
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  booth_op_t op,
    output logic      load,
    output logic      shift,
    output logic      add,
    output logic      sub,
    output logic      ready
);

    localparam int IDX_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    booth_state_t     state;
    booth_state_t     state_nx;
    logic [IDX_W-1:0] idx;
    logic             last;

    assign last = (idx == LAST_IDX);

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Index of the bit pair under examination
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            idx <= '0;
        end else if (load) begin
            idx <= '0;
        end else if (shift) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // Next state and control outputs
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        shift    = 1'b0;
        add      = 1'b0;
        sub      = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    load     = 1'b1;
                    state_nx = ST_EXAM;
                end
            end
            ST_EXAM: begin
                unique case (op)
                    OP_ADD: begin
                        add      = 1'b1;
                        state_nx = last ? ST_DONE : ST_SHIFT;
                    end
                    OP_SUB: begin
                        sub      = 1'b1;
                        state_nx = last ? ST_DONE : ST_SHIFT;
                    end
                    default: begin
                        if (last) begin
                            state_nx = ST_DONE;
                        end else begin
                            shift    = 1'b1;
                            state_nx = ST_EXAM;
                        end
                    end
                endcase
            end
            ST_SHIFT: begin
                shift    = 1'b1;
                state_nx = ST_EXAM;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign ready = ((state == ST_IDLE) && !rst) || (state == ST_DONE);

    p_ctrl_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load, shift, add, sub}));

    p_op_then_shift_r4: assert property (@(posedge clk) disable iff (rst)
        ((add || sub) && !last) |=> (shift && state == ST_SHIFT));

    p_op_last_done_r4: assert property (@(posedge clk) disable iff (rst)
        ((add || sub) && last) |=> (state == ST_DONE));

    p_load_busy_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> !ready);

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
    parameter int WORD_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WORD_W-1:0]     word_a,
    input  logic [WORD_W-1:0]     word_b,
    input  logic                  load,
    input  logic                  shift,
    input  logic                  add,
    input  logic                  sub,
    output logic [1:0]            pair,
    output logic [2*WORD_W-1:0]   product
);

    localparam int PROD_W = 2 * WORD_W;

    logic [PROD_W-1:0] mcand;
    logic [WORD_W-1:0] mplr;
    logic              prev_bit;

    assign pair = {mplr[0], prev_bit};

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            mcand    <= '0;
            mplr     <= '0;
            prev_bit <= 1'b0;
            product  <= '0;
        end else if (load) begin
            mcand    <= {{WORD_W{word_a[WORD_W-1]}}, word_a};
            mplr     <= word_b;
            prev_bit <= 1'b0;
            product  <= '0;
        end else if (shift) begin
            prev_bit <= mplr[0];
            mplr     <= mplr >> 1;
            mcand    <= mcand << 1;
        end else if (add) begin
            product  <= product + mcand;
        end else if (sub) begin
            product  <= product - mcand;
        end
    end

    p_load_clears_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (product == '0 && prev_bit == 1'b0));

    p_sub_on_begin_r3: assert property (@(posedge clk) disable iff (rst)
        sub |-> (pair == 2'b10));

    p_add_on_end_r3: assert property (@(posedge clk) disable iff (rst)
        add |-> (pair == 2'b01));

    p_sum_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(load || add || sub) |=> $stable(product));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WORD_W-1:0]   word_a,
    input  logic [WORD_W-1:0]   word_b,
    output logic                ready,
    output logic [2*WORD_W-1:0] product
);

    logic      load;
    logic      shift;
    logic      add;
    logic      sub;
    logic [1:0] pair;
    booth_op_t op;

    booth_recoder u_recoder (
        .pair (pair),
        .op   (op)
    );

    booth_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op),
        .load  (load),
        .shift (shift),
        .add   (add),
        .sub   (sub),
        .ready (ready)
    );

    booth_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .word_a  (word_a),
        .word_b  (word_b),
        .load    (load),
        .shift   (shift),
        .add     (add),
        .sub     (sub),
        .pair    (pair),
        .product (product)
    );

    p_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> (ready && $stable(product)));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> (!ready && product == '0));

endmodule

// File: tb/booth_seq_mult_tb.sv
module booth_seq_mult_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s4 = 1'b0;
    logic [3:0]  a4 = '0;
    logic [3:0]  b4 = '0;
    logic        r4;
    logic [7:0]  p4;
    logic        s8 = 1'b0;
    logic [7:0]  a8 = '0;
    logic [7:0]  b8 = '0;
    logic        r8;
    logic [15:0] p8;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    booth_seq_mult #(.WORD_W(4)) u_dut (
        .clk(clk), .rst(rst), .start(s4), .word_a(a4), .word_b(b4),
        .ready(r4), .product(p4)
    );

    booth_seq_mult #(.WORD_W(8)) u_dut_w8 (
        .clk(clk), .rst(rst), .start(s8), .word_a(a8), .word_b(b8),
        .ready(r8), .product(p8)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int w, input bit s, input int a, input int b);
        if (w == 4) begin
            s4 = s; a4 = a[3:0]; b4 = b[3:0];
        end else begin
            s8 = s; a8 = a[7:0]; b8 = b[7:0];
        end
    endtask

    function automatic int prod_of(input int w);
        if (w == 4) return int'($signed(p4));
        return int'($signed(p8));
    endfunction

    function automatic bit ready_of(input int w);
        return (w == 4) ? r4 : r8;
    endfunction

    // Clock edges from load to ready: width plus non-zero digits below the top pair
    function automatic int exp_lat(input int w, input int b);
        int n = 0;
        for (int i = 0; i < w - 1; i++) begin
            bit cur = b[i];
            bit prv = (i == 0) ? 1'b0 : b[i-1];
            if (cur != prv) n++;
        end
        return w + n;
    endfunction

    // Called at a falling edge with ready high; a and b are signed values
    task automatic run_op(input int w, input int a, input int b,
                          input bit pulse_mid, input string req);
        int cnt = 0;
        bit done = 0;
        drive(w, 1'b1, a, b);
        @(negedge clk);
        drive(w, 1'b0, a, b);
        check(ready_of(w) == 1'b0, "R6", "ready after load", ready_of(w), 0);
        check(prod_of(w) == 0, "R2", "product after load", prod_of(w), 0);
        while (!done && cnt < 4 * w) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (ready_of(w)) begin
                done = 1;
            end else if (pulse_mid && cnt == 1) begin
                drive(w, 1'b1, $urandom, $urandom);
            end else if (pulse_mid && cnt == 2) begin
                drive(w, 1'b0, $urandom, $urandom);
            end
        end
        drive(w, 1'b0, a, b);
        check(cnt == exp_lat(w, b), "R5", "latency", cnt, exp_lat(w, b));
        check(prod_of(w) == a * b, req, "product", prod_of(w), a * b);
    endtask

    initial begin
        #600000;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int held;
        void'($urandom(32'd20117));
        // R1 reset state
        #3;
        check(r4 == 1'b0, "R1", "ready in reset", r4, 0);
        check(p4 == 8'd0, "R1", "product in reset", p4, 0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(r4 == 1'b1, "R1", "ready after reset", r4, 1);
        check(r8 == 1'b1, "R1", "ready8 after reset", r8, 1);

        // Directed: sign extension and digit codes
        run_op(4, -1, 1, 1'b0, "R2");
        run_op(4, -8, -8, 1'b0, "R3");
        run_op(4, 7, -8, 1'b0, "R3");
        run_op(4, 5, 6, 1'b0, "R3");
        run_op(8, 15, -65, 1'b0, "R3");
        check(p8 == 16'hFC31, "R7", "-65 x 15 encoding", p8, 16'hFC31);
        run_op(8, -128, -128, 1'b0, "R7");
        run_op(8, 127, 85, 1'b0, "R4");

        // R9 hold while ready without start
        held = prod_of(8);
        for (int k = 0; k < 4; k++) begin
            a8 = $urandom; b8 = $urandom;
            @(negedge clk);
            check(r8 == 1'b1, "R9", "ready hold", r8, 1);
            check(prod_of(8) == held, "R9", "product hold", prod_of(8), held);
        end

        // All operand pairs at width 4, back to back from done (R8)
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                run_op(4, a, b, ((a + b) % 3) == 0, "R8");
            end
        end

        // Random pairs at width 8, with ignored mid-run stimulus (R6)
        for (int k = 0; k < 300; k++) begin
            int a = int'($signed(8'($urandom)));
            int b = int'($signed(8'($urandom)));
            run_op(8, a, b, k[0], "R6");
        end

        // R1 asynchronous reset in the middle of an operation
        drive(4, 1'b1, 3, 5);
        @(negedge clk);
        drive(4, 1'b0, 3, 5);
        @(negedge clk);
        @(negedge clk);
        #1 rst = 1'b1;
        #0.5;
        check(r4 == 1'b0, "R1", "ready during async reset", r4, 0);
        check(p4 == 8'd0, "R1", "product during async reset", p4, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(r4 == 1'b1, "R1", "ready after mid reset", r4, 1);
        run_op(4, -3, 7, 1'b0, "R7");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule